// File: doc/BRIEF.md
# Periodic Forced Wake-Up Controller

This block keeps time while the system sleeps and, when forced wake-up is switched on, brings the host back after a programmable interval. When the interval runs out, the controller leaves sleep and enters a normal-request state. It raises a one-cycle wake request and holds the host reset low for a fixed number of time-base ticks. The host software must then confirm that it has configured itself. If the confirmation comes, the controller settles in normal mode. If it does not come within 75 ms, the controller falls back to sleep and starts a fresh interval.

All timing is derived from a 1 µs time-base tick input, so the clock may run faster than the tick. If cyclic sensing of the wake inputs is enabled, it takes precedence over forced wake-up, and the interval timer is held at zero for as long as cyclic sensing stays on. A sleep command from software, accepted only in normal mode, puts the controller to sleep.

States: NORMAL (host running, code 2'b00), SLEEP (interval timing, 2'b01) and NORM_REQ (waiting for configuration, 2'b10). Transitions: NORMAL→SLEEP on the sleep command; SLEEP→NORM_REQ when the interval expires; NORM_REQ→NORMAL on the configuration-done strobe; NORM_REQ→SLEEP when the 75 ms window runs out.

Top module: `fwu_ctrl`

## Requirements
- R1: After reset, mode_o is NORMAL (2'b00), host_rst_n_o is high and wake_req_o is low.
- R2: sleep_cmd_i high in NORMAL moves mode_o to SLEEP (2'b01) at the next clock edge. In SLEEP and NORM_REQ the command is ignored.
- R3: period_sel_i values 0 to 6 select 32·2^sel ms, and value 7 selects 8192 ms. In SLEEP with fwu_en_i high and cyc_sense_en_i low, mode_o becomes NORM_REQ (2'b10) after exactly period × TICKS_PER_MS ticks have been counted from entry.
- R4: wake_req_o is high for exactly one cycle, in the cycle right after the SLEEP→NORM_REQ transition.
- R5: host_rst_n_o goes low on entry into NORM_REQ and stays low for HOST_RST_TICKS (16) ticks, even if the mode changes during that time.
- R6: cfg_done_i high in NORM_REQ moves mode_o to NORMAL at the next edge, and it wins over a timeout in the same cycle. In SLEEP it is ignored.
- R7: Without cfg_done_i, NORM_REQ lasts exactly 75 × TICKS_PER_MS ticks and then returns to SLEEP.
- R8: The interval count restarts from zero on every entry into SLEEP, including a return after a timeout.
- R9: While cyc_sense_en_i is high in SLEEP, no forced wake-up occurs. Once it drops, a full interval is counted from zero.
- R10: While fwu_en_i is low in SLEEP, no forced wake-up occurs. Once it is raised, a full interval is counted from zero.
- R11: Time advances only on tick_i. Ticks delivered every other cycle double the cycle length of every interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 µs time-base tick, one cycle wide |
| fwu_en_i | input | 1 | Forced wake-up enable |
| period_sel_i | input | 3 | Wake interval select |
| cyc_sense_en_i | input | 1 | Cyclic sense enable; overrides forced wake-up |
| cfg_done_i | input | 1 | Host configuration-complete strobe |
| sleep_cmd_i | input | 1 | Software sleep command |
| wake_req_o | output | 1 | One-cycle wake request |
| host_rst_n_o | output | 1 | Active-low reset pulse to the host |
| mode_o | output | 2 | Current mode: 00 NORMAL, 01 SLEEP, 10 NORM_REQ |

## Verification
The bench steps through all eight interval selects with one tick per cycle and compares the time spent in SLEEP against the interval computed for each select. This exposes a wrong period table or an off-by-one in the tick or millisecond counting. Even selects confirm early, odd selects let the window expire, and one run confirms in the last possible cycle. Together these separate the timeout length, the restart from zero after a timeout, and the priority of the strobe over the timeout. Further runs hold cyclic sense or the enable off across several intervals, send commands in modes that must ignore them, and slow the tick to one every two cycles to show that only ticks count.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

    localparam int MS_W = 14;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SLEEP  = 2'b01,
        MODE_NREQ   = 2'b10
    } mode_e;

    // Interval in milliseconds for a given select code.
    function automatic logic [MS_W-1:0] period_ms(input logic [2:0] sel);
        logic [MS_W-1:0] base;
        base = MS_W'(32);
        if (sel == 3'd7) begin
            return MS_W'(8192);
        end
        return base << sel;
    endfunction

endpackage

// File: rtl/fwu_prescale.sv
module fwu_prescale #(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic ms_stb
);
    localparam int PW = $clog2(TICKS_PER_MS + 1);
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0] pcnt;

    assign ms_stb = tick && (pcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr || ms_stb) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwu_ms_timer.sv
module fwu_ms_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ms_stb,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] mcnt;

    // Compare with >= so that a limit lowered mid-count still expires.
    assign done = ms_stb && (mcnt >= (limit - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt <= '0;
        end else if (clr || done) begin
            mcnt <= '0;
        end else if (ms_stb) begin
            mcnt <= mcnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwu_rst_pulse.sv
module fwu_rst_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == LAST) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fwu_ctrl.sv
module fwu_ctrl
    import fwu_pkg::*;
#(
    parameter int TICKS_PER_MS   = 1000,
    parameter int CFG_WINDOW_MS  = 75,
    parameter int HOST_RST_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       fwu_en_i,
    input  logic [2:0] period_sel_i,
    input  logic       cyc_sense_en_i,
    input  logic       cfg_done_i,
    input  logic       sleep_cmd_i,
    output logic       wake_req_o,
    output logic       host_rst_n_o,
    output logic [1:0] mode_o
);
    localparam logic [MS_W-1:0] WINDOW = MS_W'(CFG_WINDOW_MS);

    mode_e           state_q, state_d;
    logic            run, tmr_clr, ms_stb, tmr_done, enter_nreq, rst_active;
    logic [MS_W-1:0] limit;
    logic            wake_q;

    // Timer runs in SLEEP only for an unmasked forced wake, always in NORM_REQ.
    assign run = ((state_q == MODE_SLEEP) && fwu_en_i && !cyc_sense_en_i)
               || (state_q == MODE_NREQ);
    assign tmr_clr    = (state_d != state_q) || !run;
    assign limit      = (state_q == MODE_NREQ) ? WINDOW : period_ms(period_sel_i);
    assign enter_nreq = (state_q == MODE_SLEEP) && (state_d == MODE_NREQ);

    fwu_prescale #(.TICKS_PER_MS(TICKS_PER_MS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick_i),
        .ms_stb (ms_stb)
    );

    fwu_ms_timer #(.W(MS_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .ms_stb (ms_stb && run),
        .limit  (limit),
        .done   (tmr_done)
    );

    fwu_rst_pulse #(.LEN(HOST_RST_TICKS)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (enter_nreq),
        .tick   (tick_i),
        .active (rst_active)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: begin
                if (sleep_cmd_i) state_d = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (run && tmr_done) state_d = MODE_NREQ;
            end
            MODE_NREQ: begin
                if (cfg_done_i)    state_d = MODE_NORMAL;
                else if (tmr_done) state_d = MODE_SLEEP;
            end
            default: state_d = MODE_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= enter_nreq;
    end

    assign wake_req_o   = wake_q;
    assign host_rst_n_o = !rst_active;
    assign mode_o       = state_q;
endmodule

// File: rtl/fwu_ctrl_chk.sv
module fwu_ctrl_chk #(
    parameter int TICKS_PER_MS   = 1000,
    parameter int CFG_WINDOW_MS  = 75,
    parameter int HOST_RST_TICKS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       fwu_en_i,
    input logic       cyc_sense_en_i,
    input logic       cfg_done_i,
    input logic       sleep_cmd_i,
    input logic       wake_req_o,
    input logic       host_rst_n_o,
    input logic [1:0] mode_o
);
    localparam logic [1:0] M_NORMAL = 2'b00;
    localparam logic [1:0] M_SLEEP  = 2'b01;
    localparam logic [1:0] M_NREQ   = 2'b10;
    localparam int WIN_TICKS = CFG_WINDOW_MS * TICKS_PER_MS;

    int nreq_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  nreq_ticks <= 0;
        else if (mode_o != M_NREQ)   nreq_ticks <= 0;
        else if (tick_i)             nreq_ticks <= nreq_ticks + 1;
    end

    AST_SLEEP_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NORMAL && sleep_cmd_i) |=> (mode_o == M_SLEEP)); // R2

    AST_WAKE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (mode_o == M_NREQ && $past(mode_o) == M_SLEEP)); // R4

    AST_RST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NREQ && $past(mode_o) == M_SLEEP) |-> !host_rst_n_o); // R5

    AST_CFG_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NREQ && cfg_done_i) |=> (mode_o == M_NORMAL)); // R6

    AST_NR_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        nreq_ticks <= WIN_TICKS); // R7

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NREQ && $past(mode_o) == M_SLEEP)
            |-> $past(fwu_en_i && !cyc_sense_en_i)); // R9

    AST_NORMAL_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NORMAL && $past(mode_o) == M_NREQ) |-> $past(cfg_done_i)); // R6
endmodule

bind fwu_ctrl fwu_ctrl_chk #(
    .TICKS_PER_MS   (TICKS_PER_MS),
    .CFG_WINDOW_MS  (CFG_WINDOW_MS),
    .HOST_RST_TICKS (HOST_RST_TICKS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .fwu_en_i       (fwu_en_i),
    .cyc_sense_en_i (cyc_sense_en_i),
    .cfg_done_i     (cfg_done_i),
    .sleep_cmd_i    (sleep_cmd_i),
    .wake_req_o     (wake_req_o),
    .host_rst_n_o   (host_rst_n_o),
    .mode_o         (mode_o)
);

// File: tb/fwu_ctrl_tb.sv
module fwu_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 2;
    localparam int WIN_MS     = 75;
    localparam int RST_TICKS  = 16;
    localparam logic [1:0] M_NORMAL = 2'b00;
    localparam logic [1:0] M_SLEEP  = 2'b01;
    localparam logic [1:0] M_NREQ   = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       fwu_en = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       cyc_en = 1'b0;
    logic       cfg_done = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       wake;
    logic       host_rst_n;
    logic [1:0] mode;

    int checks = 0;
    int failures = 0;
    int gap = 1;
    int cycles = 0;

    fwu_ctrl #(
        .TICKS_PER_MS   (TPM),
        .CFG_WINDOW_MS  (WIN_MS),
        .HOST_RST_TICKS (RST_TICKS)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .fwu_en_i       (fwu_en),
        .period_sel_i   (sel),
        .cyc_sense_en_i (cyc_en),
        .cfg_done_i     (cfg_done),
        .sleep_cmd_i    (sleep_cmd),
        .wake_req_o     (wake),
        .host_rst_n_o   (host_rst_n),
        .mode_o         (mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator: one tick every 'gap' cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            tick = ((ph % gap) == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ms(input int s);
        return (s == 7) ? 8192 : (32 << s);
    endfunction

    task automatic go_sleep();
        @(negedge clk);
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        check(mode == M_SLEEP, "R2 sleep entry", int'(mode), int'(M_SLEEP));
    endtask

    // Counts edges until the mode leaves SLEEP; optional cfg_done pulse inside.
    task automatic measure_sleep(input bit poke_cfg, output int n);
        n = 0;
        do begin
            if (poke_cfg && n == 3) cfg_done = 1'b1;
            @(negedge clk);
            cfg_done = 1'b0;
            n++;
        end while (mode == M_SLEEP && n < 100000);
    endtask

    task automatic in_nr(input int cfg_at, output int nr_n, output int rst_lo, output int wk);
        nr_n = 0; rst_lo = 0; wk = 0;
        while (mode == M_NREQ && nr_n < 100000) begin
            nr_n++;
            if (!host_rst_n) rst_lo++;
            if (wake) wk++;
            if (nr_n == cfg_at) cfg_done = 1'b1;
            if (nr_n == 5) sleep_cmd = 1'b1;
            @(negedge clk);
            cfg_done = 1'b0;
            sleep_cmd = 1'b0;
        end
        while (!host_rst_n && rst_lo < 100000) begin
            rst_lo++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int n, nr_n, rlo, wk, exp_p;
        repeat (3) @(negedge clk);
        check(mode == M_NORMAL, "R1 mode", int'(mode), 0);
        check(host_rst_n == 1'b1, "R1 host_rst_n", int'(host_rst_n), 1);
        check(wake == 1'b0, "R1 wake", int'(wake), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mode == M_NORMAL, "R1 mode after release", int'(mode), 0);

        // R3 sweep over every select; even selects confirm, odd ones time out.
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            exp_p = exp_ms(s) * TPM;
            go_sleep();
            measure_sleep(s == 0, n);
            check(n == exp_p, "R3 sleep interval", n, exp_p);
            check(mode == M_NREQ, "R3 enters NORM_REQ", int'(mode), int'(M_NREQ));
            if (s % 2 == 0) begin
                in_nr(20, nr_n, rlo, wk);
                check(nr_n == 20, "R6 cfg_done exits NORM_REQ", nr_n, 20);
                check(mode == M_NORMAL, "R6 mode NORMAL", int'(mode), 0);
            end else begin
                in_nr(0, nr_n, rlo, wk);
                check(nr_n == WIN_MS * TPM, "R7 window length", nr_n, WIN_MS * TPM);
                check(mode == M_SLEEP, "R7 back to SLEEP", int'(mode), 1);
                check(wk == 1, "R4 wake pulse count", wk, 1);
                check(rlo == RST_TICKS, "R5 reset width", rlo, RST_TICKS);
                measure_sleep(1'b0, n);
                check(n == exp_p, "R8 restart after timeout", n, exp_p);
                in_nr((s == 1) ? WIN_MS * TPM : 20, nr_n, rlo, wk);
                check(mode == M_NORMAL, "R6 cfg_done wins over timeout", int'(mode), 0);
            end
            check(wk == 1, "R4 wake pulse count", wk, 1);
            check(rlo == RST_TICKS, "R5 reset width", rlo, RST_TICKS);
        end

        // R9 cyclic sense override
        sel = 3'd0;
        cyc_en = 1'b1;
        go_sleep();
        wk = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wake) wk++;
        end
        check(mode == M_SLEEP && wk == 0, "R9 no wake under cyclic sense", int'(mode), 1);
        cyc_en = 1'b0;
        measure_sleep(1'b0, n);
        check(n == 32 * TPM, "R9 full interval after release", n, 32 * TPM);
        in_nr(20, nr_n, rlo, wk);

        // R10 enable off
        fwu_en = 1'b0;
        go_sleep();
        repeat (200) @(negedge clk);
        check(mode == M_SLEEP, "R10 no wake while disabled", int'(mode), 1);
        fwu_en = 1'b1;
        measure_sleep(1'b0, n);
        check(n == 32 * TPM, "R10 full interval after enable", n, 32 * TPM);
        in_nr(20, nr_n, rlo, wk);

        // R11 slower tick
        gap = 2;
        go_sleep();
        measure_sleep(1'b0, n);
        check(n >= 2 * 32 * TPM - 1 && n <= 2 * 32 * TPM, "R11 interval with gapped tick", n, 2 * 32 * TPM);
        in_nr(60, nr_n, rlo, wk);
        check(rlo >= 2 * RST_TICKS - 1 && rlo <= 2 * RST_TICKS, "R11 reset width with gapped tick", rlo, 2 * RST_TICKS);
        check(mode == M_NORMAL, "R6 mode NORMAL", int'(mode), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule